// File: doc/BRIEF.md
# Dual-Processor Bus Hold Arbiter

This block lets an external bus master take over a system that has two on-board processors. Only one processor runs at a time. A select input decides which one runs and which one is held. When the external master raises its hold request, the block holds both processors. It grants the bus only after both processors have answered with their own hold acknowledge.

The grant appears on a single bus-level acknowledge output, which tells the requesting master that it may drive the bus. When the master withdraws its request, the acknowledge drops at once. One cycle later the selected processor is released, and the unselected processor stays held. The external request and both processor acknowledges enter through multi-flop synchronizers. The select input is used as it arrives.

Top module: `dual_hold_arbiter`

## Requirements
- R1: While the synchronized request is low, `cpu_sel`=0 gives `hold_a`=0 and `hold_b`=1, and `cpu_sel`=1 gives `hold_a`=1 and `hold_b`=0. The hold outputs follow `cpu_sel` one clock edge after it is sampled.
- R2: A change of `cpu_sel` while no request is active moves the two hold outputs in opposite directions on the same edge. One processor is released and the other is held.
- R3: While the synchronized request is high, both hold outputs are driven to 1 from the following edge, whatever the value of `cpu_sel`, including when `cpu_sel` changes.
- R4: `ext_hold_req`, `ack_a` and `ack_b` each pass through SYNC_STAGES flops (default 2) before use. A change at an input reaches the grant logic SYNC_STAGES edges after it is sampled.
- R5: `bus_hold_ack` is 1 only when the synchronized request and both synchronized acknowledges are 1 and both hold outputs are 1.
- R6: An acknowledge from only one processor never raises `bus_hold_ack`.
- R7: If either synchronized acknowledge drops while the request is still high, `bus_hold_ack` falls in that same cycle.
- R8: When the synchronized request falls, `bus_hold_ack` is 0 in that same cycle. On the next edge the selected processor's hold is released and the unselected hold stays at 1.
- R9: A synchronous reset (`rst`=1) leaves the processor chosen by `cpu_sel` running and the other held, with `bus_hold_ack`=0 and all synchronizer flops cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every flop |
| rst | input | 1 | Synchronous reset, active high |
| cpu_sel | input | 1 | 0 runs processor A, 1 runs processor B |
| ext_hold_req | input | 1 | Bus hold request from the external master |
| ack_a | input | 1 | Hold acknowledge from processor A |
| ack_b | input | 1 | Hold acknowledge from processor B |
| hold_a | output | 1 | Hold to processor A |
| hold_b | output | 1 | Hold to processor B |
| bus_hold_ack | output | 1 | Bus-level grant to the external master |

## Verification
The hardest case to reach is an acknowledge that drops while the request is still held: the one-cycle difference between the grant falling and the holds staying set only shows when one acknowledge is pulled low in the middle of an established grant. The stimulus therefore builds a full grant first. It then drops and restores each processor's acknowledge in turn, and flips the select line during the request. It also sends a one-cycle request pulse, which crosses the synchronizer but ends before either processor can acknowledge. A queue-based reference model in the bench predicts every output on every clock.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

    typedef struct packed {
        logic req;
        logic ack_a;
        logic ack_b;
    } sync_in_t;

    typedef struct packed {
        logic a;
        logic b;
    } hold_pair_t;

    localparam int SYNC_W = $bits(sync_in_t);

    // Holds applied when no external master wants the bus.
    function automatic hold_pair_t idle_holds(input logic sel);
        hold_pair_t h;
        h.a = sel;
        h.b = ~sel;
        return h;
    endfunction

    function automatic hold_pair_t quiesce_all();
        hold_pair_t h;
        h.a = 1'b1;
        h.b = 1'b1;
        return h;
    endfunction

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= '0;
            else     stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/arb_hold_ctrl.sv
module arb_hold_ctrl
    import hold_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       req_s,
    output hold_pair_t hold
);
    hold_pair_t hold_nx;

    always_comb begin
        if (req_s) hold_nx = quiesce_all();
        else       hold_nx = idle_holds(sel);
    end

    always_ff @(posedge clk) begin
        if (rst) hold <= idle_holds(sel);
        else     hold <= hold_nx;
    end

    // R3
    hold_both_chk: assert property (@(posedge clk) disable iff (rst)
        req_s |=> (hold.a && hold.b));

    // R1
    idle_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !req_s |=> (hold.a == $past(sel)) && (hold.b != $past(sel)));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(req_s) |=> (hold.a != hold.b));
endmodule

// File: rtl/arb_grant.sv
module arb_grant
    import hold_arb_pkg::*;
(
    input  sync_in_t   in_s,
    input  hold_pair_t hold,
    output logic       grant
);
    logic both_ack;

    assign both_ack = in_s.ack_a & in_s.ack_b;
    assign grant    = in_s.req & both_ack & hold.a & hold.b;
endmodule

// File: rtl/dual_hold_arbiter.sv
module dual_hold_arbiter
    import hold_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cpu_sel,
    input  logic ext_hold_req,
    input  logic ack_a,
    input  logic ack_b,
    output logic hold_a,
    output logic hold_b,
    output logic bus_hold_ack
);
    sync_in_t   raw_in;
    sync_in_t   in_s;
    hold_pair_t hold;
    logic       grant;

    assign raw_in = '{req: ext_hold_req, ack_a: ack_a, ack_b: ack_b};

    arb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (in_s)
    );

    arb_hold_ctrl u_hold (
        .clk   (clk),
        .rst   (rst),
        .sel   (cpu_sel),
        .req_s (in_s.req),
        .hold  (hold)
    );

    arb_grant u_grant (
        .in_s  (in_s),
        .hold  (hold),
        .grant (grant)
    );

    assign hold_a       = hold.a;
    assign hold_b       = hold.b;
    assign bus_hold_ack = grant;

    // R5
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        bus_hold_ack |-> (in_s.req && hold_a && hold_b));

    // R7
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_s.req && !(in_s.ack_a && in_s.ack_b)) |-> !bus_hold_ack);

    // R6
    single_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (in_s.ack_a != in_s.ack_b) |-> !bus_hold_ack);
endmodule

// File: tb/dual_hold_arbiter_test.sv
module dual_hold_arbiter_test;
    localparam int STG = 2;

    logic clk = 1'b0;
    logic rst, cpu_sel, ext_hold_req, ack_a, ack_b;
    logic hold_a, hold_b, bus_hold_ack;

    int checks = 0;
    int fails  = 0;
    string tag = "R9";
    bit done = 0;

    always #5 clk = ~clk;

    dual_hold_arbiter #(.SYNC_STAGES(STG)) uut (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .ext_hold_req(ext_hold_req),
        .ack_a(ack_a), .ack_b(ack_b),
        .hold_a(hold_a), .hold_b(hold_b), .bus_hold_ack(bus_hold_ack)
    );

    // Behavioural reference: input histories in queues, newest first.
    bit q_req[$];
    bit q_a[$];
    bit q_b[$];
    bit m_ha, m_hb, m_ack;

    task automatic model_clear();
        q_req.delete(); q_a.delete(); q_b.delete();
        for (int i = 0; i < STG; i++) begin
            q_req.push_back(0); q_a.push_back(0); q_b.push_back(0);
        end
    endtask

    initial model_clear();

    always @(posedge clk) begin
        if (rst) begin
            model_clear();
            m_ha = cpu_sel;
            m_hb = !cpu_sel;
        end else begin
            if (q_req[STG-1]) begin
                m_ha = 1; m_hb = 1;
            end else begin
                m_ha = cpu_sel; m_hb = !cpu_sel;
            end
            q_req.push_front(ext_hold_req); void'(q_req.pop_back());
            q_a.push_front(ack_a);          void'(q_a.pop_back());
            q_b.push_front(ack_b);          void'(q_b.pop_back());
        end
        m_ack = q_req[STG-1] && q_a[STG-1] && q_b[STG-1] && m_ha && m_hb;
    end

    task automatic check1(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done && checks > 0 || !done && $time > 12) begin
            check1("hold_a", hold_a, m_ha);
            check1("hold_b", hold_b, m_hb);
            check1("bus_hold_ack", bus_hold_ack, m_ack);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(100000 * 10);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1; cpu_sel = 0; ext_hold_req = 0; ack_a = 0; ack_b = 0;
        tag = "R9";
        step(3);
        // R9: reset state with A selected
        check1("reset hold_a", hold_a, 1'b0);
        check1("reset hold_b", hold_b, 1'b1);
        check1("reset ack", bus_hold_ack, 1'b0);
        rst = 0;
        step(2);

        // R1 / R2: select toggles
        tag = "R1";
        cpu_sel = 1; step(1);
        check1("R1 sel=1 hold_a", hold_a, 1'b1);
        check1("R1 sel=1 hold_b", hold_b, 1'b0);
        tag = "R2";
        cpu_sel = 0; step(1);
        check1("R2 flip hold_a", hold_a, 1'b0);
        check1("R2 flip hold_b", hold_b, 1'b1);
        cpu_sel = 1; step(1); cpu_sel = 0; step(2);

        // R6: only one ack, no grant
        tag = "R6";
        ext_hold_req = 1; step(4);
        ack_a = 1; step(5);
        check1("R6 single ack", bus_hold_ack, 1'b0);

        // R5 / R4: both acks -> grant after sync delay
        tag = "R4";
        ack_b = 1; step(1);
        check1("R4 not yet synced", bus_hold_ack, 1'b0);
        step(1);
        tag = "R5";
        check1("R5 grant", bus_hold_ack, 1'b1);
        step(3);

        // R3: select change during request keeps both held
        tag = "R3";
        cpu_sel = 1; step(3);
        check1("R3 hold_a", hold_a, 1'b1);
        check1("R3 hold_b", hold_b, 1'b1);
        cpu_sel = 0; step(2);

        // R7: each ack drops mid-grant
        tag = "R7";
        ack_a = 0; step(2);
        check1("R7 ack_a drop", bus_hold_ack, 1'b0);
        check1("R7 holds kept", hold_a & hold_b, 1'b1);
        ack_a = 1; step(4);
        ack_b = 0; step(2);
        check1("R7 ack_b drop", bus_hold_ack, 1'b0);
        ack_b = 1; step(4);

        // R8: request drop
        tag = "R8";
        ext_hold_req = 0; step(2);
        check1("R8 ack low", bus_hold_ack, 1'b0);
        check1("R8 still held", hold_a, 1'b1);
        step(1);
        check1("R8 sel released", hold_a, 1'b0);
        check1("R8 unsel held", hold_b, 1'b1);
        ack_a = 0; ack_b = 0; step(4);

        // R3 with B selected, then R4 one-cycle pulse
        tag = "R3";
        cpu_sel = 1; step(2);
        ext_hold_req = 1; step(4);
        ack_a = 1; ack_b = 1; step(5);
        ext_hold_req = 0; step(4);
        ack_a = 0; ack_b = 0; step(3);
        tag = "R4";
        ext_hold_req = 1; step(1); ext_hold_req = 0; step(6);

        // R9: reset with B selected
        tag = "R9";
        ext_hold_req = 1; step(3);
        rst = 1; step(2);
        check1("R9 reset sel=1 hold_a", hold_a, 1'b1);
        check1("R9 reset sel=1 hold_b", hold_b, 1'b0);
        check1("R9 reset ack", bus_hold_ack, 1'b0);
        rst = 0; ext_hold_req = 0; step(3);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule